// File: doc/BRIEF.md
# Attribute-Driven Configuration Register Bank

This block holds a small set of 32-bit configuration words behind a single synchronous request port with byte enables. Every bit of every word carries an access attribute fixed at elaboration: constant zero (reserved), read-only, read/write, write-1-to-clear, write-once, or lockable. Software reaches the words through word addresses. Hardware reaches the status field through a set-pulse input.

Reset loads a default value into every word. The read-only byte of word 0 is loaded from strap inputs for as long as reset is held. A single lock bit is itself write-once. Once the lock bit is set, every lockable bit is frozen until the next reset.

Every request receives an acknowledge one cycle later. This includes requests to the reserved word and to addresses outside the map. Both complete normally and read as zero.

Word map (word address):
- Word 0:
  - bits 7:0 are read-only and take their value from the straps.
  - bits 15:8 are read/write, default 0xA5.
  - bits 23:16 are write-1-to-clear status bits. Input `hwSet[i]` sets bit 16+i.
  - bits 31:24 are reserved.
- Word 1:
  - bits 7:0 are write-once.
  - bits 15:8 are write-once.
  - bit 16 is the write-once lock bit.
  - bits 31:17 are reserved.
- Word 2:
  - bits 15:0 are lockable, default 0x1234.
  - bits 31:16 are read/write, default 0x00C3.
- Word 3 is fully reserved.
- Addresses 4 and above are unmapped.

Top module: `cfg_reg_bank`

## Requirements
- R1: While `rstN` is low, every word takes its default value, and word 0 bits 7:0 follow `strapIn`. Defaults: word 0 = 0x0000A500 OR strap, word 1 = 0, word 2 = 0x00C31234, word 3 = 0.
- R2: Writes leave the read-only strap byte (word 0 bits 7:0) unchanged.
- R3: A read/write bit takes the write data only when the byte enable of its lane (`reqBe[k]` covers bits 8k+7:8k) is set.
- R4: On an enabled lane, writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A `hwSet` pulse sets the bit one cycle later.
- R5: When `hwSet` and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: Each write-once byte lane accepts only the first write that enables that lane after reset. Later writes to that lane are ignored. A write with the lane disabled does not use up the lane.
- R7: The lock bit (word 1 bit 16) is write-once and never falls outside reset. While it is 1, writes leave word 2 bits 15:0 unchanged.
- R8: Reserved bits, the reserved word 3 and unmapped addresses read as zero, and writes to them have no effect.
- R9: `rspAck` is high exactly in the cycle after an accepted request (`reqValid`). `rspRdata` then carries the word read, and it is zero for writes.
- R10: A new reset restores all defaults, clears the lock, re-arms every write-once lane and resamples the straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqBe | input | 4 | Byte enables for the write lanes |
| reqWdata | input | 32 | Write data |
| hwSet | input | 8 | Hardware set pulses for the status bits |
| strapIn | input | 8 | Strap value loaded during reset |
| rspAck | output | 1 | Acknowledge, one cycle after the request |
| rspRdata | output | 32 | Registered read data, valid with `rspAck` |

## Verification
Internal state in this block is visible only through reads, so a wrong bit shows up at `rspRdata` one cycle after the next read of its word. Examples of such faults are a lane flag that failed to latch, a lock that dropped, or a status bit that lost a set race. The bench keeps a bitwise model of every word, the lane flags and the lock. It sweeps every address against every byte-enable combination with a readback after each write. As a result, any divergence surfaces within two accesses of the offending write.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int NUM_REGS = 4;
  localparam int STRAP_W  = 8;
  localparam int STAT_REG = 0;
  localparam int STAT_LSB = 16;
  localparam int STAT_W   = 8;
  localparam int LOCK_REG = 1;
  localparam int LOCK_BIT = 16;

  typedef enum logic [2:0] {
    ATTR_RSV, ATTR_RO, ATTR_RW, ATTR_W1C, ATTR_WO, ATTR_LK
  } attrT;

  typedef struct packed {
    logic                wr;
    logic                rd;
    logic                hit;
    logic [NUM_REGS-1:0] sel;
    logic [BE_W-1:0]     be;
  } strobeT;

  function automatic attrT attrOf(int r, int b);
    attrT a;
    a = ATTR_RSV;
    case (r)
      0: begin
        if (b < 8)       a = ATTR_RO;
        else if (b < 16) a = ATTR_RW;
        else if (b < 24) a = ATTR_W1C;
      end
      1: if (b <= LOCK_BIT) a = ATTR_WO;
      2: a = (b < 16) ? ATTR_LK : ATTR_RW;
      default: a = ATTR_RSV;
    endcase
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] defaultOf(int r);
    case (r)
      0:       return 32'h0000_A500;
      2:       return 32'h00C3_1234;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] attrMask(int r, attrT a);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++) m[b] = (attrOf(r, b) == a);
    return m;
  endfunction

  function automatic bit laneHasWo(int r, int l);
    bit h;
    h = 1'b0;
    for (int b = 8 * l; b < 8 * l + 8; b++) if (attrOf(r, b) == ATTR_WO) h = 1'b1;
    return h;
  endfunction
endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqBe,
  output strobeT            strb,
  output logic              rspAck
);
  localparam logic [ADDR_W:0] MAP_END = (ADDR_W + 1)'(NUM_REGS);

  always_comb begin
    strb     = '0;
    strb.wr  = reqValid & reqWrite;
    strb.rd  = reqValid & ~reqWrite;
    strb.be  = reqBe;
    strb.hit = reqValid & ({1'b0, reqAddr} < MAP_END);
    for (int r = 0; r < NUM_REGS; r++)
      strb.sel[r] = strb.hit & (reqAddr == ADDR_W'(r));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspAck <= 1'b0;
    else       rspAck <= reqValid;
  end

  // R9
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspAck);
  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspAck);
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.sel));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [STAT_W-1:0]  hwSet,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [DATA_W-1:0]  rdata
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regWord;
  logic [NUM_REGS-1:0][BE_W-1:0]   woDone;
  logic [DATA_W-1:0]               rdWord;
  logic                            lockQ;

  assign lockQ = regWord[LOCK_REG][LOCK_BIT];

  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    localparam logic [DATA_W-1:0] DEF = defaultOf(r);
    localparam logic [DATA_W-1:0] LKM = attrMask(r, ATTR_LK);
    localparam logic [DATA_W-1:0] ROM = attrMask(r, ATTR_RO);

    for (genvar l = 0; l < BE_W; l++) begin : gLane
      if (laneHasWo(r, l)) begin : gFlag
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                                  woDone[r][l] <= 1'b0;
          else if (strb.wr && strb.sel[r] && strb.be[l]) woDone[r][l] <= 1'b1;
        end
        // R6
        wo_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
          !$fell(woDone[r][l]));
      end else begin : gNoFlag
        assign woDone[r][l] = 1'b0;
      end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : gBit
      localparam attrT A = attrOf(r, b);
      localparam int   L = b / 8;
      if (A == ATTR_RSV) begin : gRsv
        assign regWord[r][b] = 1'b0;
      end else if (A == ATTR_RO) begin : gRo
        logic q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q <= strapIn[b % STRAP_W];
          else       q <= q;
        end
        assign regWord[r][b] = q;
      end else if (A == ATTR_RW) begin : gRw
        logic q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                                     q <= DEF[b];
          else if (strb.wr && strb.sel[r] && strb.be[L]) q <= wdata[b];
        end
        assign regWord[r][b] = q;
      end else if (A == ATTR_W1C) begin : gW1c
        logic q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                                                 q <= DEF[b];
          else if (hwSet[(b - STAT_LSB) % STAT_W])                   q <= 1'b1;
          else if (strb.wr && strb.sel[r] && strb.be[L] && wdata[b]) q <= 1'b0;
        end
        assign regWord[r][b] = q;
        // R5
        set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
          hwSet[(b - STAT_LSB) % STAT_W] |=> regWord[r][b]);
      end else if (A == ATTR_WO) begin : gWo
        logic q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q <= DEF[b];
          else if (strb.wr && strb.sel[r] && strb.be[L] && !woDone[r][L]) q <= wdata[b];
        end
        assign regWord[r][b] = q;
      end else begin : gLk
        logic q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q <= DEF[b];
          else if (strb.wr && strb.sel[r] && strb.be[L] && !lockQ) q <= wdata[b];
        end
        assign regWord[r][b] = q;
      end
    end

    if (LKM != '0) begin : gLkChk
      // R7
      lock_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
        lockQ |=> $stable(regWord[r] & LKM));
    end
    if (ROM != '0) begin : gRoChk
      // R2
      ro_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wr |=> $stable(regWord[r] & ROM));
    end
  end

  always_comb begin
    rdWord = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (strb.sel[r]) rdWord |= regWord[r];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else       rdata <= strb.rd ? rdWord : '0;
  end

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(lockQ));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && !strb.hit) |=> (rdata == '0));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [BE_W-1:0]    reqBe,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [STAT_W-1:0]  hwSet,
  input  logic [STRAP_W-1:0] strapIn,
  output logic               rspAck,
  output logic [DATA_W-1:0]  rspRdata
);
  strobeT strb;

  cfg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqBe    (reqBe),
    .strb     (strb),
    .rspAck   (rspAck)
  );

  cfg_regs regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (reqWdata),
    .hwSet   (hwSet),
    .strapIn (strapIn),
    .rdata   (rspRdata)
  );
endmodule

// File: tb/cfg_reg_bank_tb_top.sv
`timescale 1ns/1ps
module cfg_reg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [3:0]  reqAddr = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic [7:0]  hwSet = '0;
  logic [7:0]  strapIn = '0;
  logic        rspAck;
  logic [31:0] rspRdata;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] mdl [4];
  bit          woUsed [3];

  always #4 clk = ~clk;

  cfg_reg_bank #(.ADDR_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata), .hwSet(hwSet),
    .strapIn(strapIn), .rspAck(rspAck), .rspRdata(rspRdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] beMask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic modelReset(input logic [7:0] s);
    mdl[0] = 32'h0000_A500 | {24'h0, s};
    mdl[1] = 32'h0;
    mdl[2] = 32'h00C3_1234;
    mdl[3] = 32'h0;
    for (int l = 0; l < 3; l++) woUsed[l] = 1'b0;
  endtask

  task automatic modelWrite(input logic [3:0] a, input logic [31:0] d,
                            input logic [3:0] be, input logic [7:0] hs);
    logic [31:0] m;
    logic [31:0] lkm;
    m = beMask(be);
    if (a == 4'd0) begin
      mdl[0] = (mdl[0] & ~(32'h0000_FF00 & m)) | (d & 32'h0000_FF00 & m);
      mdl[0] = mdl[0] & ~(d & 32'h00FF_0000 & m);
    end else if (a == 4'd1) begin
      for (int l = 0; l < 3; l++) begin
        if (be[l] && !woUsed[l]) begin
          woUsed[l] = 1'b1;
          lkm = (32'hFF << (8 * l)) & 32'h0001_FFFF;
          mdl[1] = (mdl[1] & ~lkm) | (d & lkm);
        end
      end
    end else if (a == 4'd2) begin
      lkm = (mdl[1][16] ? 32'h0 : 32'h0000_FFFF) | 32'hFFFF_0000;
      lkm = lkm & m;
      mdl[2] = (mdl[2] & ~lkm) | (d & lkm);
    end
    mdl[0][23:16] = mdl[0][23:16] | hs;
  endtask

  task automatic access(input bit wr, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic [7:0] hs,
                        output logic [31:0] rd, output logic ack);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be; hwSet = hs;
    @(negedge clk);
    ack = rspAck; rd = rspRdata;
    reqValid = 1'b0; reqWrite = 1'b0; hwSet = '0;
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d,
                         input logic [3:0] be, input logic [7:0] hs);
    logic [31:0] rd;
    logic ack;
    access(1'b1, a, d, be, hs, rd, ack);
    modelWrite(a, d, be, hs);
    chk("R9 write ack", {31'h0, ack}, 32'h1);
    chk("R9 write rdata zero", rd, 32'h0);
  endtask

  task automatic doRead(input logic [3:0] a, input string tag);
    logic [31:0] rd;
    logic ack;
    logic [31:0] exp;
    access(1'b0, a, 32'h0, 4'h0, 8'h0, rd, ack);
    exp = (a < 4'd4) ? mdl[a[1:0]] : 32'h0;
    chk("R9 read ack", {31'h0, ack}, 32'h1);
    chk(tag, rd, exp);
  endtask

  task automatic applyReset(input logic [7:0] s);
    @(negedge clk);
    rstN = 1'b0; strapIn = 8'h00;
    repeat (2) @(negedge clk);
    strapIn = s;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    strapIn = ~s;
    modelReset(s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    applyReset(8'h3C);
    @(negedge clk);
    chk("R9 idle ack low", {31'h0, rspAck}, 32'h0);
    // R1 / R8: defaults and zero on reserved / unmapped
    for (int a = 0; a < 16; a++) doRead(4'(a), "R1 R8 reset value");

    // R2: strap byte ignores writes
    doWrite(4'd0, 32'h0000_00FF, 4'h1, 8'h0);
    doRead(4'd0, "R2 read-only byte");
    chk("R2 strap byte", {24'h0, mdl[0][7:0]}, 32'h3C);

    // R3: byte-enabled read/write
    doWrite(4'd2, 32'h7E00_0000, 4'h8, 8'h0);
    doRead(4'd2, "R3 upper lane only");
    chk("R3 expected word", mdl[2], 32'h7EC3_1234);

    // R4: status set by hardware, cleared by write-1
    doWrite(4'd3, 32'h0, 4'h0, 8'hF0);
    doRead(4'd0, "R4 hw set");
    doWrite(4'd0, 32'h0030_0000, 4'h4, 8'h0);
    doRead(4'd0, "R4 clear by one");
    doWrite(4'd0, 32'h0000_0000, 4'h4, 8'h0);
    doRead(4'd0, "R4 zero no effect");
    chk("R4 status field", {24'h0, mdl[0][23:16]}, 32'hC0);

    // R5: set beats clear in the same cycle
    doWrite(4'd0, 32'h0080_0000, 4'h4, 8'h80);
    doRead(4'd0, "R5 set wins");

    // R6: write-once lanes
    doWrite(4'd1, 32'h0000_0011, 4'h0, 8'h0);
    doRead(4'd1, "R6 disabled lane not consumed");
    doWrite(4'd1, 32'h0000_0011, 4'h1, 8'h0);
    doWrite(4'd1, 32'h0000_2222, 4'h3, 8'h0);
    doRead(4'd1, "R6 lane0 once lane1 first");
    chk("R6 expected word", mdl[1], 32'h0000_2211);

    // R7: lock freezes lockable bits, lock is sticky
    doWrite(4'd2, 32'hAAAA_1111, 4'hF, 8'h0);
    doWrite(4'd1, 32'h0001_0000, 4'h4, 8'h0);
    doWrite(4'd2, 32'h5555_2222, 4'hF, 8'h0);
    doRead(4'd2, "R7 frozen after lock");
    chk("R7 expected word", mdl[2], 32'h5555_1111);
    doWrite(4'd1, 32'h0000_0000, 4'h4, 8'h0);
    doRead(4'd1, "R7 lock sticky");

    // R8: writes to reserved / unmapped have no effect
    doWrite(4'd3, 32'hFFFF_FFFF, 4'hF, 8'h0);
    doWrite(4'd9, 32'hFFFF_FFFF, 4'hF, 8'h0);
    doRead(4'd3, "R8 reserved word");
    doRead(4'd9, "R8 unmapped");
    doWrite(4'd0, 32'hFF00_0000, 4'h8, 8'h0);
    doRead(4'd0, "R8 reserved byte");

    // R10: second reset with a new strap
    applyReset(8'hC3);
    for (int a = 0; a < 4; a++) doRead(4'(a), "R10 reset restore");
    doWrite(4'd2, 32'h0000_BEEF, 4'h3, 8'h0);
    doRead(4'd2, "R10 lock released");
    doWrite(4'd1, 32'h0000_0077, 4'h1, 8'h0);
    doRead(4'd1, "R10 write-once re-armed");

    // R3 sweep: every address against every byte-enable set
    applyReset(8'h5A);
    for (int a = 0; a < 16; a++) begin
      for (int be = 0; be < 16; be++) begin
        logic [31:0] d;
        d = 32'h9E37_79B9 * (a * 16 + be + 1);
        doWrite(4'(a), d, 4'(be), (a == 0) ? d[31:24] : 8'h0);
        doRead(4'(a), "R3 sweep readback");
      end
    end
    for (int a = 0; a < 4; a++) doRead(4'(a), "R6 R7 sweep final");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule